// File: doc/BRIEF.md
# Serial DMA Interrupt Cause Aggregator

This block collects interrupt events from a set of serial DMA channels and holds them in one cause register. Each channel has a 4-bit field of event flags. A DMA engine reports an event by pulsing a valid strobe with a channel number and a 4-bit event code. The code is OR-ed into that channel's field, so a pending flag is never lost when a new event arrives.

Host software acknowledges events by writing ones to the bits it wants to clear. The block reduces the cause register at two levels. First, each channel's field reduces to one summary bit in a serial summary vector; these bits sit at every second bit position. Second, all channel summaries reduce to a single global bit, which is also driven out as the high-level cause bit. The interrupt request is the global bit gated by an enable and registered.

Top module: `dma_irq_agg`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `cause`, `ser_cause`, `high_sum` and `irq` are all zero.
- R2: A clock edge with `ev_valid` high ORs `ev_code` into `cause[4n+3:4n]`, where n = `ev_chan`. Within a field, bit 0 is TX buffer done, bit 1 is RX buffer ready, bit 2 is TX end and bit 3 is RX error. Every other bit keeps its value.
- R3: A clock edge with `clr_we` high clears each `cause` bit whose `clr_mask` bit is 1. Bits with a 0 in `clr_mask` are left unchanged.
- R4: If an event sets a bit in the same cycle that a host clear targets it, the set wins and the bit is 1 after the edge.
- R5: `ser_cause[2n]` is 1 exactly when any bit of `cause[4n+3:4n]` is 1, and it follows `cause` with no added delay. The odd bits below position 2·NCH always read 0.
- R6: `ser_cause[2*NCH]` and `high_sum` are both 1 exactly when any channel summary bit is 1, in the same cycle as `cause`.
- R7: `irq` equals `high_sum & irq_en` as sampled at the previous clock edge.
- R8: A clock edge with both `ev_valid` and `clr_we` low leaves `cause` unchanged. An `ev_chan` value of NCH or above is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event strobe |
| ev_chan | input | CW | Channel that raised the event |
| ev_code | input | 4 | Event flags to OR into the channel's field |
| clr_we | input | 1 | Host write-one-to-clear strobe |
| clr_mask | input | 4*NCH | Bits to clear |
| irq_en | input | 1 | Interrupt enable |
| cause | output | 4*NCH | Event cause register |
| ser_cause | output | 2*NCH+1 | Channel summaries at even positions, global summary at the top bit |
| high_sum | output | 1 | Global summary for the high-level cause |
| irq | output | 1 | Registered interrupt request |

## Verification
Two functions can act in the same cycle: a channel event setting bits and a host clear removing them. The bench provokes this overlap deliberately. It issues an event whose code overlaps the clear mask, so a bit is both set and cleared in one edge, and the same edge also clears unrelated bits. The reference model then expects two outcomes. The overlapping bits must survive, and the other masked bits must drop. On every cycle the model also checks that the channel summaries, the global summary and the delayed request move together.

// File: rtl/dma_irq_agg.sv
module dma_irq_agg #(
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int FW = 4 * NCH,
  localparam int SW = 2 * NCH + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  logic [CW-1:0] ev_chan,
  input  logic [3:0]    ev_code,
  input  logic          clr_we,
  input  logic [FW-1:0] clr_mask,
  input  logic          irq_en,
  output logic [FW-1:0] cause,
  output logic [SW-1:0] ser_cause,
  output logic          high_sum,
  output logic          irq
);

  logic [FW-1:0]  cause_q;
  logic [FW-1:0]  set_vec;
  logic [FW-1:0]  clr_vec;
  logic [NCH-1:0] ch_sum;
  logic           irq_q;

  always_comb begin
    set_vec = '0;
    if (ev_valid && (int'(ev_chan) < NCH))
      set_vec[int'(ev_chan)*4 +: 4] = ev_code;
  end

  assign clr_vec = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      cause_q <= (cause_q & ~clr_vec) | set_vec;
      irq_q   <= high_sum & irq_en;
    end
  end

  genvar n;
  generate
    for (n = 0; n < NCH; n++) begin : g_ch
      assign ch_sum[n]         = |cause_q[4*n +: 4];
      assign ser_cause[2*n]    = ch_sum[n];
      assign ser_cause[2*n+1]  = 1'b0;
    end
  endgenerate

  assign high_sum       = |ch_sum;
  assign ser_cause[SW-1] = high_sum;
  assign cause          = cause_q;
  assign irq            = irq_q;

endmodule

// File: rtl/dma_irq_agg_chk.sv
module dma_irq_agg_chk #(
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int FW = 4 * NCH,
  localparam int SW = 2 * NCH + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_valid,
  input logic [CW-1:0] ev_chan,
  input logic [3:0]    ev_code,
  input logic          clr_we,
  input logic [FW-1:0] clr_mask,
  input logic          irq_en,
  input logic [FW-1:0] cause,
  input logic [SW-1:0] ser_cause,
  input logic          high_sum,
  input logic          irq
);

  logic [FW-1:0] ev_bits;
  always_comb begin
    ev_bits = '0;
    if (int'(ev_chan) < NCH) ev_bits[int'(ev_chan)*4 +: 4] = ev_code;
  end

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> ((cause & $past(ev_bits)) == $past(ev_bits)));

  assert_clear_works_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !ev_valid) |=> ((cause & $past(clr_mask)) == '0));

  assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && ev_valid) |=> ((cause & $past(ev_bits)) == $past(ev_bits)));

  assert_global_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (high_sum == (cause != '0)) && (ser_cause[SW-1] == high_sum));

  assert_irq_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == ($past(high_sum) & $past(irq_en))));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid && !clr_we) |=> $stable(cause));

  genvar n;
  generate
    for (n = 0; n < NCH; n++) begin : g_sum
      assert_chan_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_cause[2*n] == (cause[4*n +: 4] != 4'h0)) && !ser_cause[2*n+1]);
    end
  endgenerate

endmodule

bind dma_irq_agg dma_irq_agg_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_chan(ev_chan),
  .ev_code(ev_code), .clr_we(clr_we), .clr_mask(clr_mask), .irq_en(irq_en),
  .cause(cause), .ser_cause(ser_cause), .high_sum(high_sum), .irq(irq)
);

// File: tb/test_dma_irq_agg.sv
`timescale 1ns/1ps
module test_dma_irq_agg;
  localparam int NCH = 2;
  localparam int CW  = 1;
  localparam int FW  = 4 * NCH;
  localparam int SW  = 2 * NCH + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [CW-1:0] ev_chan = '0;
  logic [3:0] ev_code = '0;
  logic clr_we = 1'b0;
  logic [FW-1:0] clr_mask = '0;
  logic irq_en = 1'b0;
  logic [FW-1:0] cause;
  logic [SW-1:0] ser_cause;
  logic high_sum, irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  bit m_cause [FW];
  bit m_irq;

  always #2 clk = ~clk;

  dma_irq_agg #(.NCH(NCH)) i_dma_irq_agg (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_chan(ev_chan),
    .ev_code(ev_code), .clr_we(clr_we), .clr_mask(clr_mask), .irq_en(irq_en),
    .cause(cause), .ser_cause(ser_cause), .high_sum(high_sum), .irq(irq)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int any_set();
    for (int b = 0; b < FW; b++) if (m_cause[b]) return 1;
    return 0;
  endfunction

  task automatic compare(string tag);
    int exp_c = 0;
    int exp_s = 0;
    for (int b = 0; b < FW; b++) if (m_cause[b]) exp_c += (1 << b);
    for (int c = 0; c < NCH; c++) begin
      int hit = 0;
      for (int k = 0; k < 4; k++) if (m_cause[4*c+k]) hit = 1;
      if (hit) exp_s += (1 << (2*c));
    end
    if (any_set()) exp_s += (1 << (2*NCH));
    chk(tag, "cause", int'(cause), exp_c);
    chk("R5", "ser_cause", int'(ser_cause), exp_s);
    chk("R6", "high_sum", int'(high_sum), any_set());
    chk("R7", "irq", int'(irq), int'(m_irq));
  endtask

  // drive one cycle of stimulus, update the model at the edge, check after
  task automatic step(string tag, bit v, int ch, int code, bit cw, int mask, bit en);
    int nxt_irq;
    ev_valid = v; ev_chan = CW'(ch); ev_code = 4'(code);
    clr_we = cw; clr_mask = FW'(mask); irq_en = en;
    @(posedge clk);
    nxt_irq = any_set() & int'(en);
    if (cw) for (int b = 0; b < FW; b++) if ((mask >> b) & 1) m_cause[b] = 0;
    if (v && ch < NCH) for (int k = 0; k < 4; k++) if ((code >> k) & 1) m_cause[4*ch+k] = 1;
    m_irq = nxt_irq[0];
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    for (int b = 0; b < FW; b++) m_cause[b] = 0;
    m_irq = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2: each flag of each channel, accumulating
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 4; k++) step("R2", 1, c, 1 << k, 0, 0, 0);
    // R8: idle cycles hold state
    step("R8", 0, 1, 4'hF, 0, 0, 0);
    step("R8", 0, 0, 4'hF, 0, 8'hFF, 0);
    // R3: partial clears
    step("R3", 0, 0, 0, 1, 8'h0A, 1);
    step("R3", 0, 0, 0, 1, 8'h50, 1);
    step("R3", 0, 0, 0, 1, 8'hFF, 1);
    step("R7", 0, 0, 0, 0, 0, 1);
    // R2: new event does not clear pending flags
    step("R2", 1, 1, 4'h2, 0, 0, 1);
    step("R2", 1, 1, 4'h8, 0, 0, 1);
    // R4: set and clear of the same bits in one edge
    step("R4", 1, 1, 4'h2, 1, 8'hFF, 1);
    step("R4", 1, 0, 4'h5, 1, 8'h25, 0);
    // R7: enable toggling
    step("R7", 0, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 1);
    step("R7", 0, 0, 0, 1, 8'hFF, 1);
    step("R7", 0, 0, 0, 0, 0, 1);
    // mixed patterns
    for (int i = 0; i < 300; i++)
      step("R2", ($urandom % 2) == 1, $urandom % NCH, $urandom % 16,
           ($urandom % 3) == 0, $urandom % 256, ($urandom % 4) != 0);
    // R1: reset mid-run clears everything
    ev_valid = 0; clr_we = 0; rst_n = 1'b0;
    @(posedge clk);
    for (int b = 0; b < FW; b++) m_cause[b] = 0;
    m_irq = 0;
    @(negedge clk);
    compare("R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule